// File: doc/BRIEF.md
# Width-Converting Single-Channel DMA Mover

This block copies a programmed number of source elements from a source address range to a destination address range over one synchronous memory request port. The width of a source element and the width of a destination beat are chosen on their own, each 1, 2 or 4 bytes. When the destination beat is wider, the block reads several source elements and packs them into one destination write. When the source element is wider, it splits each element into several destination writes.

Software-side logic applies the configuration inputs and pulses `start` while the mover is idle. The configuration is captured on that edge. The mover then issues reads and writes until the element count is used up, and reports completion with a one-cycle `done` pulse. A configuration that cannot fill its last destination beat is refused with a one-cycle `error` pulse, and memory is not touched.

Top module: `dma_width_mover`

## Requirements
- R1: `elem_count` counts source-width elements. A transfer moves exactly `elem_count × source bytes` bytes and issues `elem_count × source bytes / destination bytes` writes.
- R2: Width codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Bus data is right-justified: an n-byte access uses `mem_wdata`/`mem_rdata` bits [8n-1:0], with the byte at the lowest address in bits [7:0].
- R3: When the destination is wider, each write carries destination/source consecutive source elements. The first element read sits in the lowest byte lanes, so bytes 11,22,33,44 read singly give the word 0x44332211.
- R4: When the source is wider, each source element becomes source/destination writes, lowest bytes first.
- R5: With stepping enabled, the source address advances by the source width after each read and the destination address advances by the destination width after each write.
- R6: With stepping disabled on a side, every access on that side uses the base address captured at start.
- R7: If the destination is wider and `elem_count × source bytes` is not a multiple of the destination bytes, or a width code is 3, `error` pulses for one cycle and no memory request is made.
- R8: After the final write, `done` is high for exactly one cycle. `busy` falls on the next cycle and `done` and `error` are never high together.
- R9: A `start` pulse while `busy` is high is ignored, and so is the configuration presented with it.
- R10: A start with `elem_count` of zero gives a `done` pulse and no memory request.
- R11: At most one request is issued per cycle, and only while `busy`. Read data is taken on the cycle after a read request, and that cycle carries no request.
- R12: During and right after reset, `busy`, `done`, `error` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| src_base | input | AW | First source address |
| dst_base | input | AW | First destination address |
| src_wcode | input | 2 | Source element width code |
| dst_wcode | input | 2 | Destination beat width code |
| elem_count | input | CW | Number of source elements |
| src_step_en | input | 1 | Advance source address per read |
| dst_step_en | input | 1 | Advance destination address per write |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_size | output | 2 | Request width code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle refusal pulse |

## Verification
The cases hardest to reach from the ports are the partial packing states: a destination word half-built from gathered reads, or a source word only partly split into writes. Every combination of widths, counts 0 to 6 and all four stepping modes is swept, so each gather and split position is reached, including the mismatched counts that must be refused. The destination region is then compared byte for byte with a model built from the byte stream. A second start is injected in the middle of a transfer, and memory around it is checked to show nothing moved.

// File: rtl/dmw_pkg.sv
// Shared types and helpers for the width-converting DMA mover.
// Assumes a 32-bit data bus; width codes 0/1/2 mean 1/2/4 bytes.
package dmw_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RDW,
        ST_WR,
        ST_DONE,
        ST_ERR
    } dmw_state_e;

    // Byte-lane mask for a right-justified access of the given width code.
    function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] wcode);
        case (wcode)
            2'd0:    lane_mask = 32'h0000_00FF;
            2'd1:    lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/dmw_cfg_check.sv
// Configuration validator: flags illegal width codes and element counts
// that cannot fill the final packed destination beat.
// Assumes inputs are stable in the cycle start is sampled.
module dmw_cfg_check #(
    parameter int CW = 12
) (
    input  logic [1:0]    sw,
    input  logic [1:0]    dw,
    input  logic [CW-1:0] count,
    output logic          bad
);
    logic [CW-1:0] low_bits;

    // Decide whether the programmed geometry is legal.
    always_comb begin
        low_bits = '0;
        if (dw > sw) begin
            low_bits = (CW'(1) << (dw - sw)) - CW'(1);
        end
        bad = (sw == 2'd3) || (dw == 2'd3) || ((count & low_bits) != '0);
    end
endmodule

// File: rtl/dmw_addr_step.sv
// Address generator for one side of the mover: loads a base address and
// advances by the side's width on each step when stepping is enabled.
// Assumes step is never asserted in the same cycle as load.
module dmw_addr_step #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    input  logic          inc_en,
    input  logic [1:0]    wcode,
    output logic [AW-1:0] addr
);
    // Hold or advance the current address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (step && inc_en) begin
            addr <= addr + (AW'(1) << wcode);
        end
    end
endmodule

// File: rtl/dmw_pack.sv
// Data packer: gathers narrow source reads into a staging word at rising
// lane offsets, and presents slices of it as destination write data.
// Assumes gidx is 0 unless dw > sw and pidx is 0 unless sw > dw.
module dmw_pack
    import dmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [BUS_W-1:0] rdata,
    input  logic [1:0]       sw,
    input  logic [1:0]       dw,
    input  logic [1:0]       gidx,
    input  logic [1:0]       pidx,
    output logic [BUS_W-1:0] wdata
);
    logic [BUS_W-1:0] stage_q;
    logic [5:0]       put_sh;
    logic [5:0]       get_sh;

    // Bit offsets for the gather lane and the split slice.
    always_comb begin
        put_sh = {1'b0, gidx, 3'b000} << sw;
        get_sh = {1'b0, pidx, 3'b000} << dw;
    end

    // Stage a read element into its lane; the first lane restarts the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (capture) begin
            stage_q <= ((gidx == 2'd0) ? '0 : stage_q)
                     | ((rdata & lane_mask(sw)) << put_sh);
        end
    end

    // Right-justified slice for the current write beat.
    always_comb begin
        wdata = (stage_q >> get_sh) & lane_mask(dw);
    end
endmodule

// File: rtl/dma_width_mover.sv
// Single-channel DMA mover with independent source and destination widths.
// Counts source elements; gathers reads when the destination is wider and
// splits reads when the source is wider. Assumes a memory that accepts
// every request and returns read data on the following cycle.
module dma_width_mover
    import dmw_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [1:0]       src_wcode,
    input  logic [1:0]       dst_wcode,
    input  logic [CW-1:0]    elem_count,
    input  logic             src_step_en,
    input  logic             dst_step_en,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [BUS_W-1:0] mem_wdata,
    input  logic [BUS_W-1:0] mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             error
);
    dmw_state_e    st;
    logic [1:0]    c_sw;
    logic [1:0]    c_dw;
    logic          c_sinc;
    logic          c_dinc;
    logic [CW-1:0] remain;
    logic [1:0]    gidx;
    logic [1:0]    pidx;
    logic          cfg_bad;
    logic          accept;
    logic          rd_issue;
    logic          wr_issue;
    logic          gather_mode;
    logic          split_mode;
    logic [1:0]    gather_last;
    logic [1:0]    piece_last;
    logic [CW-1:0] dec_w;
    logic          final_wr;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;

    dmw_cfg_check #(.CW(CW)) u_cfg (
        .sw    (src_wcode),
        .dw    (dst_wcode),
        .count (elem_count),
        .bad   (cfg_bad)
    );

    // Decode the captured geometry into packing limits and count decrement.
    always_comb begin
        gather_mode = c_dw > c_sw;
        split_mode  = c_sw > c_dw;
        gather_last = gather_mode ? 2'((3'd1 << (c_dw - c_sw)) - 3'd1) : 2'd0;
        piece_last  = split_mode  ? 2'((3'd1 << (c_sw - c_dw)) - 3'd1) : 2'd0;
        dec_w       = gather_mode ? (CW'(1) << (c_dw - c_sw)) : CW'(1);
        final_wr    = split_mode ? ((pidx == piece_last) && (remain == CW'(1)))
                                 : (remain == dec_w);
    end

    // Strobes for the request port and the address generators.
    always_comb begin
        busy     = (st != ST_IDLE);
        accept   = start && !busy;
        rd_issue = (st == ST_RD);
        wr_issue = (st == ST_WR);
        done     = (st == ST_DONE);
        error    = (st == ST_ERR);
        mem_req  = rd_issue || wr_issue;
        mem_we   = wr_issue;
        mem_addr = wr_issue ? dst_addr : src_addr;
        mem_size = wr_issue ? c_dw : c_sw;
    end

    // Capture the configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_sw   <= 2'd0;
            c_dw   <= 2'd0;
            c_sinc <= 1'b0;
            c_dinc <= 1'b0;
        end else if (accept) begin
            c_sw   <= src_wcode;
            c_dw   <= dst_wcode;
            c_sinc <= src_step_en;
            c_dinc <= dst_step_en;
        end
    end

    // Main sequencer: read, take data, write until the count is used up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            remain <= '0;
            gidx   <= 2'd0;
            pidx   <= 2'd0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        remain <= elem_count;
                        gidx   <= 2'd0;
                        pidx   <= 2'd0;
                        if (cfg_bad) begin
                            st <= ST_ERR;
                        end else if (elem_count == '0) begin
                            st <= ST_DONE;
                        end else begin
                            st <= ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    st <= ST_RDW;
                end
                ST_RDW: begin
                    if (gather_mode && (gidx != gather_last)) begin
                        gidx <= gidx + 2'd1;
                        st   <= ST_RD;
                    end else begin
                        gidx <= 2'd0;
                        st   <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (split_mode && (pidx != piece_last)) begin
                        pidx <= pidx + 2'd1;
                    end else begin
                        pidx   <= 2'd0;
                        remain <= remain - dec_w;
                        st     <= final_wr ? ST_DONE : ST_RD;
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    dmw_addr_step #(.AW(AW)) u_src_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .base   (src_base),
        .step   (rd_issue),
        .inc_en (c_sinc),
        .wcode  (c_sw),
        .addr   (src_addr)
    );

    dmw_addr_step #(.AW(AW)) u_dst_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .base   (dst_base),
        .step   (wr_issue),
        .inc_en (c_dinc),
        .wcode  (c_dw),
        .addr   (dst_addr)
    );

    dmw_pack u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (st == ST_RDW),
        .rdata   (mem_rdata),
        .sw      (c_sw),
        .dw      (c_dw),
        .gidx    (gidx),
        .pidx    (pidx),
        .wdata   (mem_wdata)
    );
endmodule

// File: rtl/dmw_checker.sv
// Protocol and address-stepping checks for the DMA mover, bound to every
// instance of the top. Assumes the top's captured configuration is visible.
module dmw_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    c_sw,
    input logic [1:0]    c_dw,
    input logic          c_sinc,
    input logic          c_dinc
);
    logic          have_w;
    logic          have_r;
    logic [AW-1:0] last_w;
    logic [AW-1:0] last_r;

    // Remember the previous read and write address within a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || (start && !busy)) begin
            have_w <= 1'b0;
            have_r <= 1'b0;
            last_w <= '0;
            last_r <= '0;
        end else if (mem_req) begin
            if (mem_we) begin
                have_w <= 1'b1;
                last_w <= mem_addr;
            end else begin
                have_r <= 1'b1;
                last_r <= mem_addr;
            end
        end
    end

    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && have_w) |->
        (mem_addr == last_w + (c_dinc ? (AW'(1) << c_dw) : AW'(0)))); // R5
    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && have_r) |->
        (mem_addr == last_r + (c_sinc ? (AW'(1) << c_sw) : AW'(0)))); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R8
    AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !mem_req); // R7
    AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R11
    AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req); // R11
    AST_BUSY_START_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(c_sw) && $stable(c_dw) && $stable(c_dinc))); // R9
endmodule

bind dma_width_mover dmw_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .c_sw     (c_sw),
    .c_dw     (c_dw),
    .c_sinc   (c_sinc),
    .c_dinc   (c_dinc)
);

// File: tb/sim_dma_width_mover.sv
module sim_dma_width_mover;
    localparam int AW = 16;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0;
    logic [AW-1:0] dst_base = '0;
    logic [1:0]    src_wcode = '0;
    logic [1:0]    dst_wcode = '0;
    logic [CW-1:0] elem_count = '0;
    logic          src_step_en = 1'b0;
    logic          dst_step_en = 1'b0;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          busy;
    logic          done;
    logic          error;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int wr_seen = 0;
    int req_seen = 0;
    bit literal_seed = 1'b0;
    logic [7:0] mem [0:255];
    logic [7:0] expv [0:255];

    always #4 clk = ~clk;

    dma_width_mover #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .src_wcode(src_wcode), .dst_wcode(dst_wcode),
        .elem_count(elem_count),
        .src_step_en(src_step_en), .dst_step_en(dst_step_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .error(error)
    );

    // Byte-addressed memory: right-justified data, read data a cycle later.
    always @(posedge clk) begin
        if (mem_req) begin
            req_seen = req_seen + 1;
            if (mem_we) begin
                wr_seen = wr_seen + 1;
                for (int k = 0; k < (1 << mem_size); k++)
                    mem[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                              mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]}
                             & ((mem_size == 2'd0) ? 32'hFF :
                                (mem_size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF);
            end
        end
    end

    // Watchdog: a hung run is a failure but still reports.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] seed(input int a);
        if (literal_seed && a >= 16 && a < 20) return 8'(8'h11 * (a - 15));
        return 8'(a * 37 + 11);
    endfunction

    // One transfer: model expected memory, run, compare (optionally poke a
    // second start while busy, which must change nothing).
    task automatic run_case(input int sw, input int dw, input int cnt,
                            input bit si, input bit di, input bit poke);
        int sb = 1 << sw;
        int db = 1 << dw;
        int sbase = 16;
        int dbase = 128;
        bit bad;
        int n_done = 0;
        int n_err = 0;
        int n_wr;
        int mism = 0;
        bad = (sw > 2) || (dw > 2) || (dw > sw && ((cnt * sb) % db) != 0);
        for (int a = 0; a < 256; a++) begin
            mem[a] = seed(a);
            expv[a] = seed(a);
        end
        n_wr = (bad || cnt == 0) ? 0 : (cnt * sb) / db;
        for (int j = 0; j < n_wr; j++)
            for (int k = 0; k < db; k++) begin
                int i = j * db + k;
                expv[dbase + (di ? j * db : 0) + k] =
                    seed(sbase + (si ? (i / sb) * sb : 0) + (i % sb));
            end
        @(negedge clk);
        wr_seen = 0;
        req_seen = 0;
        src_base = AW'(sbase);
        dst_base = AW'(dbase);
        src_wcode = 2'(sw);
        dst_wcode = 2'(dw);
        elem_count = CW'(cnt);
        src_step_en = si;
        dst_step_en = di;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 400; t++) begin
            if (poke && t == 2) begin
                dst_base = 16'h00C0;
                dst_wcode = 2'd0;
                elem_count = CW'(1);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) n_done++;
            if (error) n_err++;
            if (!busy) break;
            @(negedge clk);
        end
        start = 1'b0;
        for (int a = 0; a < 256; a++) if (mem[a] !== expv[a]) mism++;
        if (bad) begin
            chk(n_err == 1 && n_done == 0, "R7 refusal pulse", n_err, 1);
            chk(req_seen == 0, "R7 no request on refusal", req_seen, 0);
        end else if (cnt == 0) begin
            chk(n_done == 1 && req_seen == 0, "R10 empty transfer", req_seen, 0);
        end else begin
            chk(n_done == 1 && n_err == 0, "R8 single done pulse", n_done, 1);
            chk(wr_seen == n_wr, "R1 write count", wr_seen, n_wr);
            if (dw > sw)
                chk(mism == 0, "R3 gathered data", mism, 0);
            else if (sw > dw)
                chk(mism == 0, "R4 split data", mism, 0);
            else
                chk(mism == 0, "R5 R6 copied data", mism, 0);
        end
        if (poke)
            chk(mism == 0 && wr_seen == n_wr, "R9 start while busy ignored", mism, 0);
        chk(!busy && !done && !error, "R8 idle after outcome", busy, 0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !mem_req, "R12 reset outputs", {busy, done, error, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !error && !mem_req, "R12 after reset", {busy, done, error, mem_req}, 0);

        // Full sweep of widths, counts and stepping modes (R1 to R7, R10).
        for (int sw = 0; sw < 3; sw++)
            for (int dw = 0; dw < 3; dw++)
                for (int cnt = 0; cnt < 7; cnt++)
                    for (int m = 0; m < 4; m++)
                        run_case(sw, dw, cnt, m[0], m[1], 1'b0);

        // R2 R3: single bytes 11,22,33,44 form one little-endian word.
        literal_seed = 1'b1;
        run_case(0, 2, 4, 1'b1, 1'b1, 1'b0);
        chk({mem[131], mem[130], mem[129], mem[128]} == 32'h44332211, "R3 literal word",
            {mem[131], mem[130], mem[129], mem[128]}, 32'h44332211);
        literal_seed = 1'b0;

        // R7: illegal width code.
        run_case(3, 0, 2, 1'b1, 1'b1, 1'b0);
        run_case(1, 3, 2, 1'b1, 1'b1, 1'b0);

        // R9: second start during a transfer.
        run_case(0, 0, 6, 1'b1, 1'b1, 1'b1);
        run_case(2, 0, 2, 1'b1, 1'b1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule